// File: doc/BRIEF.md
# Row-Table Video Address Generator

This block supplies the character address for each position on the active display when rows are located through a table of pointers held in video memory. A running counter does not supply them. Each data row starts wherever its table entry points. Rows can therefore be repeated, reordered, inserted or removed by editing pointers alone, without moving any character data. The timing generator drives strobes for frame start, row-entry fetch, scan-line start and character tick. The block returns a 14-bit address bus with a valid flag and an output enable for a shared, tri-stated bus.

At frame start the table pointer is loaded from a base-address input. The timing generator pulses the fetch strobe during the horizontal blanking before each new data row. The block then reads that row's entry through a simple request/response memory port. The table is walked in one of two layouts, chosen by a mode input:

- **Contiguous:** each entry is one start-address word, and the next entry follows at a fixed stride.
- **Linked:** each entry is two words, the start address followed by the address of the next entry.

On each scan-line start the character address is loaded from the current row start and then advances by one per character tick. The first line after a completed fetch switches to the newly fetched row. Later lines reuse the same start address, which suits designs with no row buffer.

Top module: `rowtab_addr_gen`

## Requirements
- R1: After reset, vaddr_o is 0, and vaddr_valid_o, vaddr_oe_o and mem_req_o are all 0.
- R2: frame_start_i loads the table pointer from tbl_base_i. The next entry read is issued at that address, and any read in progress is abandoned.
- R3: With link_mode_i = 0, a fetch makes exactly one read, at the table pointer. The pointer then advances by STRIDE (default 1) words, modulo 2^14.
- R4: With link_mode_i = 1, a fetch reads the pointer address (row start), then pointer+1 (next entry). The pointer then takes the second word read.
- R5: line_start_i following a completed fetch drives vaddr_o to the fetched row start on the next cycle, with vaddr_valid_o = 1.
- R6: While valid, vaddr_o increases by one on each cycle with char_tick_i = 1 and holds otherwise.
- R7: vaddr_valid_o stays high for exactly chars_i character ticks after line_start_i, then falls. A value of 0 gives no valid cycle.
- R8: A line_start_i with no fetch completed since the previous one reloads the same row start address.
- R9: vaddr_oe_o = 1 exactly when vaddr_valid_o = 1 and bus_release_i = 0. bus_release_i has no effect on vaddr_o or vaddr_valid_o.
- R10: The character address wraps from 0x3FFF to 0x0000.
- R11: mem_req_o stays high, with mem_addr_o unchanged, until mem_rvalid_i = 1 (unless frame_start_i aborts the read).
- R12: frame_start_i during a table read drops mem_req_o on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_mode_i | input | 1 | 1 = linked-list table, 0 = contiguous table |
| tbl_base_i | input | 14 | Table base address loaded at frame start |
| chars_i | input | 8 | Characters per data row |
| frame_start_i | input | 1 | Frame start strobe |
| row_fetch_i | input | 1 | Fetch strobe for the next row's table entry |
| line_start_i | input | 1 | Start of a displayed scan line |
| char_tick_i | input | 1 | Character clock enable |
| bus_release_i | input | 1 | Force the address bus to high impedance |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 14 | Table read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 14 | Read data (pointer word) |
| vaddr_o | output | 14 | Character address |
| vaddr_valid_o | output | 1 | Character address valid |
| vaddr_oe_o | output | 1 | Address bus output enable |

## Verification
The address walk is exercised with both table layouts. The contiguous run shows that the pointer steps by the stride without a second read. The linked run uses entries placed out of order, so a pointer that merely incremented would land on the wrong row. Repeated line starts without a fetch separate row-start reuse from row advance. Gapped ticks and a table entry near the top of memory expose hold and wraparound errors. Slow memory responses and a frame start issued mid-read test request holding and abort.

// File: rtl/rowtab_pkg.sv
package rowtab_pkg;
  typedef enum logic [1:0] {
    FT_IDLE,
    FT_ENTRY,
    FT_LINK
  } fetch_st_e;
endpackage

// File: rtl/rt_fetch.sv
module rt_fetch
  import rowtab_pkg::*;
#(
  parameter int AW     = 14,
  parameter int STRIDE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_mode_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic          frame_start_i,
  input  logic          row_fetch_i,
  input  logic          consume_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic [AW-1:0] row_start_o
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);
  localparam logic [AW-1:0] LINK_OFS = AW'(1);

  fetch_st_e     state_q;
  logic [AW-1:0] tbl_ptr_q, row_next_q, row_cur_q;
  logic          pend_q, done;

  assign done = mem_rvalid_i &&
                ((state_q == FT_ENTRY && !link_mode_i) || state_q == FT_LINK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FT_IDLE;
      tbl_ptr_q  <= '0;
      row_next_q <= '0;
    end else if (frame_start_i) begin
      state_q   <= FT_IDLE;
      tbl_ptr_q <= tbl_base_i;
    end else begin
      unique case (state_q)
        FT_IDLE: if (row_fetch_i) state_q <= FT_ENTRY;
        FT_ENTRY: if (mem_rvalid_i) begin
          row_next_q <= mem_rdata_i;
          if (link_mode_i) begin
            state_q <= FT_LINK;
          end else begin
            tbl_ptr_q <= tbl_ptr_q + STEP;
            state_q   <= FT_IDLE;
          end
        end
        FT_LINK: if (mem_rvalid_i) begin
          tbl_ptr_q <= mem_rdata_i;
          state_q   <= FT_IDLE;
        end
        default: state_q <= FT_IDLE;
      endcase
    end
  end

  // pending flag: a fetched row waits for the next line start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      row_cur_q <= '0;
    end else begin
      if (consume_i && pend_q) row_cur_q <= row_next_q;
      if (frame_start_i)  pend_q <= 1'b0;
      else if (done)      pend_q <= 1'b1;
      else if (consume_i) pend_q <= 1'b0;
    end
  end

  assign mem_req_o   = (state_q != FT_IDLE);
  assign mem_addr_o  = (state_q == FT_LINK) ? tbl_ptr_q + LINK_OFS : tbl_ptr_q;
  assign row_start_o = pend_q ? row_next_q : row_cur_q;
endmodule

// File: rtl/rt_char_ctr.sv
module rt_char_ctr #(
  parameter int AW = 14,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic [AW-1:0] row_start_i,
  input  logic          char_tick_i,
  input  logic [CW-1:0] chars_i,
  output logic [AW-1:0] addr_o,
  output logic          active_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (line_start_i) begin
      addr_q <= row_start_i;
      cnt_q  <= '0;
      act_q  <= (chars_i != '0);
    end else if (act_q && char_tick_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q + ONE;
      if (cnt_q == chars_i - ONE) act_q <= 1'b0;
    end
  end

  assign addr_o   = addr_q;
  assign active_o = act_q;
endmodule

// File: rtl/rowtab_addr_gen.sv
module rowtab_addr_gen #(
  parameter int AW     = 14,
  parameter int CW     = 8,
  parameter int STRIDE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_mode_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [CW-1:0] chars_i,
  input  logic          frame_start_i,
  input  logic          row_fetch_i,
  input  logic          line_start_i,
  input  logic          char_tick_i,
  input  logic          bus_release_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic [AW-1:0] vaddr_o,
  output logic          vaddr_valid_o,
  output logic          vaddr_oe_o
);
  logic [AW-1:0] row_start;

  rt_fetch #(.AW(AW), .STRIDE(STRIDE)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .link_mode_i  (link_mode_i),
    .tbl_base_i   (tbl_base_i),
    .frame_start_i(frame_start_i),
    .row_fetch_i  (row_fetch_i),
    .consume_i    (line_start_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .row_start_o  (row_start)
  );

  rt_char_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .row_start_i (row_start),
    .char_tick_i (char_tick_i),
    .chars_i     (chars_i),
    .addr_o      (vaddr_o),
    .active_o    (vaddr_valid_o)
  );

  assign vaddr_oe_o = vaddr_valid_o && !bus_release_i;
endmodule

// File: rtl/rowtab_addr_gen_chk.sv
module rowtab_addr_gen_chk #(
  parameter int AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          link_mode_i,
  input logic          frame_start_i,
  input logic          line_start_i,
  input logic          char_tick_i,
  input logic          bus_release_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic [AW-1:0] vaddr_o,
  input logic          vaddr_valid_o,
  input logic          vaddr_oe_o
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i && !frame_start_i |=> mem_req_o && $stable(mem_addr_o));

  // R12
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !mem_req_o);

  // R3
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_mode_i && mem_req_o && mem_rvalid_i && !frame_start_i |=> !mem_req_o);

  // R6
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_valid_o && char_tick_i && !line_start_i |=> vaddr_o == $past(vaddr_o) + AW'(1));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vaddr_valid_o && !char_tick_i && !line_start_i |=> $stable(vaddr_o));

  // R7
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vaddr_valid_o) |-> $past(line_start_i));

  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_release_i |-> !vaddr_oe_o);
endmodule

bind rowtab_addr_gen rowtab_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .link_mode_i  (link_mode_i),
  .frame_start_i(frame_start_i),
  .line_start_i (line_start_i),
  .char_tick_i  (char_tick_i),
  .bus_release_i(bus_release_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .vaddr_o      (vaddr_o),
  .vaddr_valid_o(vaddr_valid_o),
  .vaddr_oe_o   (vaddr_oe_o)
);

// File: tb/rowtab_addr_gen_test.sv
`timescale 1ns/1ps
module rowtab_addr_gen_test;
  localparam int AW = 14;
  localparam int MSK = 16'h3FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic link = 1'b0, fs = 1'b0, rf = 1'b0, ls = 1'b0, tick = 1'b0, rel = 1'b0;
  logic [AW-1:0] base = '0;
  logic [7:0] chars = 8'd0;
  logic rvalid = 1'b0;
  logic [AW-1:0] rdata = '0;
  logic req, valid, oe;
  logic [AW-1:0] maddr, vaddr;

  int total = 0, bad = 0, lat = 0, wc = 0;
  bit finished = 0;
  int mem [int];

  // model state
  int m_ptr, m_st, m_rn, m_cur, m_addr, m_cnt;
  bit m_pend, m_act;

  always #4 clk = ~clk;

  rowtab_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .link_mode_i(link), .tbl_base_i(base),
    .chars_i(chars), .frame_start_i(fs), .row_fetch_i(rf), .line_start_i(ls),
    .char_tick_i(tick), .bus_release_i(rel), .mem_req_o(req), .mem_addr_o(maddr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .vaddr_o(vaddr),
    .vaddr_valid_o(valid), .vaddr_oe_o(oe)
  );

  function automatic int rd(int a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk or negedge rst_n) begin : mdl
    int start;
    if (!rst_n) begin
      m_ptr = 0; m_st = 0; m_rn = 0; m_cur = 0; m_addr = 0; m_cnt = 0;
      m_pend = 0; m_act = 0;
    end else begin
      if (ls) begin
        start = m_pend ? m_rn : m_cur;
        if (m_pend) begin m_cur = m_rn; m_pend = 0; end
        m_addr = start; m_cnt = 0; m_act = (chars != 0);
      end else if (m_act && tick) begin
        m_addr = (m_addr + 1) & MSK;
        if (m_cnt == chars - 1) m_act = 0;
        m_cnt++;
      end
      if (fs) begin
        m_ptr = base; m_st = 0; m_pend = 0;
      end else begin
        case (m_st)
          0: if (rf) m_st = 1;
          1: if (rvalid) begin
            m_rn = rdata;
            if (link) m_st = 2;
            else begin m_ptr = (m_ptr + 1) & MSK; m_st = 0; m_pend = 1; end
          end
          default: if (rvalid) begin m_ptr = rdata; m_st = 0; m_pend = 1; end
        endcase
      end
    end
  end

  // per-cycle compare, then memory responder
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 R6 R8 R10 vaddr", vaddr, m_addr);
      chk("R7 valid", valid, m_act);
      chk("R9 oe", oe, m_act && !rel);
      chk("R3 R4 R11 R12 req", req, m_st != 0);
      if (req) chk("R2 R3 R4 mem_addr", maddr, m_st == 2 ? (m_ptr + 1) & MSK : m_ptr);
    end
    if (req && !rvalid) begin
      if (wc >= lat) begin rvalid = 1'b1; rdata = AW'(rd(maddr)); wc = 0; end
      else wc++;
    end else begin
      rvalid = 1'b0;
      if (!req) wc = 0;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic pulse_fs();  fs = 1; step(); fs = 0; endtask
  task automatic pulse_rf();  rf = 1; step(); rf = 0; endtask
  task automatic pulse_ls();  ls = 1; step(); ls = 0; endtask
  task automatic ticks(int n); tick = 1; repeat (n) step(); tick = 0; endtask
  task automatic wait_idle();
    for (int i = 0; i < 60 && req; i++) step();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    mem[16'h100] = 16'h0200; mem[16'h101] = 16'h3FFE; mem[16'h102] = 16'h02A0;
    mem[16'h800] = 16'h1000; mem[16'h801] = 16'h0900;
    mem[16'h900] = 16'h1234; mem[16'h901] = 16'h0800;
    repeat (3) step();
    chk("R1 vaddr", vaddr, 0); chk("R1 valid", valid, 0);
    chk("R1 oe", oe, 0); chk("R1 req", req, 0);
    rst_n = 1; step();

    // contiguous table
    link = 0; base = 14'h100; chars = 8'd5;
    pulse_fs();
    pulse_rf();
    chk("R2 first read at base", maddr, 'h100);
    wait_idle();
    pulse_ls();
    chk("R5 row start", vaddr, 'h200); chk("R5 valid", valid, 1);
    ticks(4);
    chk("R6 after 4 ticks", vaddr, 'h204); chk("R7 still valid", valid, 1);
    ticks(1);
    chk("R7 valid ends", valid, 0);
    pulse_ls();
    chk("R8 reuse row start", vaddr, 'h200);
    ticks(1); step(); step();
    chk("R6 hold without tick", vaddr, 'h201);
    rel = 1; #1;
    chk("R9 oe released", oe, 0); chk("R9 valid kept", valid, 1);
    chk("R9 vaddr kept", vaddr, 'h201);
    rel = 0; #1;
    chk("R9 oe back", oe, 1);
    ticks(4);
    pulse_rf();
    chk("R3 next entry", maddr, 'h101);
    wait_idle();
    chars = 8'd4;
    pulse_ls();
    chk("R10 start", vaddr, 'h3FFE);
    ticks(2);
    chk("R10 wrap", vaddr, 0);
    ticks(2);
    chars = 8'd0;
    pulse_ls();
    chk("R7 zero chars", valid, 0);

    // linked table, slow memory
    link = 1; base = 14'h800; chars = 8'd3; lat = 3;
    pulse_fs();
    pulse_rf();
    chk("R2 linked base", maddr, 'h800);
    step(); step();
    chk("R11 req held", req, 1); chk("R11 addr held", maddr, 'h800);
    wait_idle();
    pulse_ls();
    chk("R4 linked row start", vaddr, 'h1000);
    ticks(3);
    pulse_rf();
    chk("R4 next entry from link", maddr, 'h900);
    wait_idle();
    pulse_ls();
    chk("R4 second row", vaddr, 'h1234);
    ticks(3);

    // abort mid-read
    pulse_rf();
    pulse_fs();
    chk("R12 req dropped", req, 0);
    lat = 0;
    pulse_rf();
    chk("R2 restart at base", maddr, 'h800);
    wait_idle();
    pulse_ls();
    chk("R2 first row again", vaddr, 'h1000);
    ticks(3);
    step();
    finish_run();
  end
endmodule